// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a slave-only SMBus target that keeps a small bank of 8-bit control registers for a clock fan-out stage. A host writes them with an indexed block write: after the address byte it sends a starting register index, then a byte count, then that many data bytes, which land in consecutive registers. To read, the host writes the index, issues a repeated start with the read bit set, and the target answers with a byte count followed by register contents from the index onward until the host refuses a byte.

SCL and SDA are brought into the system clock domain through two-flop synchronisers, and start and stop conditions are recognised as SDA edges while SCL is high. The target never drives SDA high: it only pulls the line low through an open-drain enable, changing that enable only while SCL is low. The four writable registers are exposed as parallel outputs; a fifth register holds a fixed identification byte.

Top module: `smb_idx_regs`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x6E (binary 1101110, sent MSB first, followed by the R/W bit in bit 0). On any other address it does not acknowledge and keeps SDA released for every later byte until the next start.
- R2: A write frame is address with R/W=0, register index, byte count N, then N data bytes; every one of these bytes is acknowledged and data byte k goes to register index+k.
- R3: A byte count of zero is not acknowledged, no register changes, and any data bytes that follow are not acknowledged.
- R4: Data bytes beyond the byte count are not acknowledged and write nothing.
- R5: After reset the outputs read ctl0_o=0x07 (bit0 divide-by-one, bit1 PLL mode, bit2 low bandwidth, bits 3 to 7 zero), oe_mask_o=0xFF, stop_mask_o=0x00, spare_o=0x00; registers 0 to 3 drive these ports in that order.
- R6: Register 4 returns ID_BYTE (default 0x5A) and ignores writes; indices 5 and above read 0x00 and ignore writes.
- R7: In a read, after the repeated start and address with R/W=1, the target returns the byte count 0x05 first, then register data MSB first from the stored index onward, and releases SDA once the host does not acknowledge a byte.
- R8: The target changes its SDA enable only while SCL is low; a stop ends the transfer at once (registers already written keep their value) and a start at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ctl0_o | output | 8 | Register 0: divider, PLL/fan-out, bandwidth and tristate controls |
| oe_mask_o | output | 8 | Register 1: per-output enables |
| stop_mask_o | output | 8 | Register 2: per-output stop masks |
| spare_o | output | 8 | Register 3: reserved read/write byte |

## Verification
The bench aims at the byte count edges: a zero count, which a faulty target would acknowledge and then write into register 0, and a count shorter than the data, where a faulty target keeps writing past the end. Writes that run over the read-only identification byte and into empty indices check that the pointer keeps advancing without corrupting anything, and a stop in the middle of a block checks that earlier bytes stay written. A wrong address followed by more bytes catches a target that acknowledges foreign traffic, and reads with the host refusing the last byte catch a target that keeps driving SDA into the stop.

// File: rtl/smb_idx_regs.sv
module smb_idx_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter logic [7:0] ID_BYTE  = 8'h5A,
  parameter logic [7:0] R0_INIT  = 8'h07,
  parameter logic [7:0] R1_INIT  = 8'hFF,
  parameter logic [7:0] R2_INIT  = 8'h00,
  parameter logic [7:0] R3_INIT  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] ctl0_o,
  output logic [7:0] oe_mask_o,
  output logic [7:0] stop_mask_o,
  output logic [7:0] spare_o
);
  localparam int          NRW      = 4;
  localparam logic [7:0]  BANK_LEN = 8'(NRW + 1);
  localparam logic [2:0]  S_IDLE = 3'd0, S_ADDR = 3'd1, S_OFS = 3'd2,
                          S_CNT  = 3'd3, S_WDATA = 3'd4, S_RDATA = 3'd5;

  logic [2:0] scl_q, sda_q;
  logic [2:0] st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txd, ptr, cnt;
  logic       first, nack;
  logic [7:0] rf [NRW];

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire start_evt = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  wire stop_evt  = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  wire scl_rise  = scl_s & ~scl_q[2];
  wire scl_fall  = ~scl_s & scl_q[2];

  wire [7:0] rd_byte = (ptr < 8'(NRW)) ? rf[ptr[1:0]] :
                       (ptr == 8'(NRW)) ? ID_BYTE : 8'h00;
  wire [7:0] tx_next = first ? BANK_LEN : rd_byte;

  assign ctl0_o      = rf[0];
  assign oe_mask_o   = rf[1];
  assign stop_mask_o = rf[2];
  assign spare_o     = rf[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txd    <= '0;
      ptr    <= '0;
      cnt    <= '0;
      first  <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      rf[0]  <= R0_INIT;
      rf[1]  <= R1_INIT;
      rf[2]  <= R2_INIT;
      rf[3]  <= R3_INIT;
    end else if (start_evt) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      first  <= 1'b1;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
        if (bitcnt < 4'd8 && st != S_RDATA) shreg <= {shreg[6:0], sda_s};
        if (bitcnt == 4'd8 && st == S_RDATA) nack <= sda_s;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            S_ADDR:
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                st     <= shreg[0] ? S_RDATA : S_OFS;
              end else st <= S_IDLE;
            S_OFS: begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
              st     <= S_CNT;
            end
            S_CNT:
              if (shreg == 8'h00) st <= S_IDLE;
              else begin
                cnt    <= shreg;
                sda_oe <= 1'b1;
                st     <= S_WDATA;
              end
            S_WDATA:
              if (cnt != 8'h00) begin
                sda_oe <= 1'b1;
                cnt    <= cnt - 8'd1;
                ptr    <= ptr + 8'd1;
                if (ptr < 8'(NRW)) rf[ptr[1:0]] <= shreg;
              end else st <= S_IDLE;
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (st == S_RDATA) begin
            if (nack) begin
              st     <= S_IDLE;
              sda_oe <= 1'b0;
            end else begin
              txd    <= tx_next;
              sda_oe <= ~tx_next[7];
              first  <= 1'b0;
              if (!first) ptr <= ptr + 8'd1;
            end
          end else sda_oe <= 1'b0;
        end else if (st == S_RDATA && bitcnt != 4'd0) begin
          sda_oe <= ~txd[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end
endmodule

module smb_idx_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       idle,
  input logic       in_wdata,
  input logic       zero_cnt_evt,
  input logic [7:0] r0,
  input logic [7:0] r1,
  input logic [7:0] r2,
  input logic [7:0] r3
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  a_r3_zero_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt_evt |=> (idle && !sda_oe));

  a_r5_regs_hold_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_wdata) |-> ($stable(r0) && $stable(r1) && $stable(r2) && $stable(r3)));
endmodule

bind smb_idx_regs smb_idx_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt),
  .idle(st == S_IDLE), .in_wdata(st == S_WDATA),
  .zero_cnt_evt(scl_fall && bitcnt == 4'd8 && st == S_CNT && shreg == 8'h00),
  .r0(ctl0_o), .r1(oe_mask_o), .r2(stop_mask_o), .r3(spare_o)
);

// File: tb/test_smb_idx_regs.sv
`timescale 1ns/1ps
module test_smb_idx_regs;
  localparam logic [6:0] ADDR = 7'h6E;
  localparam logic [7:0] ID   = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [7:0] ctl0, oem, stm, spr;
  wire sda_line = m_sda & ~sda_oe;

  int n_cmp = 0, n_bad = 0;
  bit ready = 0, done = 0;
  logic [7:0] mreg [4];

  always #2.5 clk = ~clk;

  smb_idx_regs i_smb_idx_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .ctl0_o(ctl0), .oe_mask_o(oem), .stop_mask_o(stm), .spare_o(spr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of the register outputs against the model (R2, R5)
  always @(negedge clk) if (ready && m_scl) begin
    chk(ctl0 == mreg[0], "R2 reg0 mirror", ctl0, mreg[0]);
    chk(oem  == mreg[1], "R2 reg1 mirror", oem,  mreg[1]);
    chk(stm  == mreg[2], "R2 reg2 mirror", stm,  mreg[2]);
    chk(spr  == mreg[3], "R2 reg3 mirror", spr,  mreg[3]);
  end

  task automatic q(); repeat (10) @(negedge clk); endtask

  task automatic do_start();
    m_sda = 1; q(); m_scl = 1; q(); m_sda = 0; q(); m_scl = 0; q();
  endtask

  task automatic do_stop();
    m_sda = 0; q(); m_scl = 1; q(); m_sda = 1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int widx,
                           input string tag);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); m_scl = 1; q(); q(); m_scl = 0; q();
    end
    m_sda = 1; q(); m_scl = 1;
    if (widx >= 0 && widx < 4) mreg[widx] = b;
    q(); ack = (sda_line == 1'b0);
    chk(ack == exp_ack, tag, ack, exp_ack);
    q(); m_scl = 0; q();
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      q(); m_scl = 1; q(); v = {v[6:0], sda_line}; q(); m_scl = 0;
    end
    q(); m_sda = mack ? 1'b0 : 1'b1; q(); m_scl = 1; q(); q(); m_scl = 0; q(); m_sda = 1;
  endtask

  task automatic wr_block(input logic [6:0] a, input logic [7:0] ofs, input logic [7:0] n,
                          input logic [7:0] d[$], input string tag);
    bit match = (a == ADDR);
    bit alive;
    int p = ofs;
    do_start();
    send_byte({a, 1'b0}, match, -1, {"R1 address ack ", tag});
    if (!match) begin
      send_byte(ofs, 0, -1, {"R1 ignored index ", tag});
      send_byte(n, 0, -1, {"R1 ignored count ", tag});
      foreach (d[i]) send_byte(d[i], 0, -1, {"R1 ignored data ", tag});
      do_stop();
      return;
    end
    send_byte(ofs, 1, -1, {"R2 index ack ", tag});
    send_byte(n, n != 0, -1, {"R3 count ack ", tag});
    alive = (n != 0);
    foreach (d[i]) begin
      bit ok = alive && (i < n);
      send_byte(d[i], ok, ok ? p : -1, {"R4 data ack ", tag});
      if (ok) p++; else alive = 0;
    end
    do_stop();
    chk(sda_oe == 0, {"R8 released after stop ", tag}, sda_oe, 0);
  endtask

  task automatic rd_block(input logic [7:0] ofs, input int len, input string tag);
    logic [7:0] v, e;
    int p = ofs;
    do_start();
    send_byte({ADDR, 1'b0}, 1, -1, {"R7 address ack ", tag});
    send_byte(ofs, 1, -1, {"R7 index ack ", tag});
    m_sda = 1; q(); m_scl = 1; q(); m_sda = 0; q(); m_scl = 0; q();
    send_byte({ADDR, 1'b1}, 1, -1, {"R7 read address ack ", tag});
    read_byte(1, v);
    chk(v == 8'h05, {"R7 byte count ", tag}, v, 8'h05);
    for (int i = 0; i < len; i++) begin
      read_byte(i != len - 1, v);
      e = (p < 4) ? mreg[p] : (p == 4) ? ID : 8'h00;
      chk(v == e, (p >= 4) ? {"R6 read data ", tag} : {"R7 read data ", tag}, v, e);
      p++;
    end
    q();
    chk(sda_oe == 0, {"R7 released after host NACK ", tag}, sda_oe, 0);
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mreg[0] = 8'h07; mreg[1] = 8'hFF; mreg[2] = 8'h00; mreg[3] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R5 reset sda released", sda_oe, 0);
    chk(ctl0 == 8'h07, "R5 reset reg0", ctl0, 8'h07);
    chk(oem == 8'hFF, "R5 reset reg1", oem, 8'hFF);
    chk(stm == 8'h00, "R5 reset reg2", stm, 8'h00);
    chk(spr == 8'h00, "R5 reset reg3", spr, 8'h00);
    ready = 1;

    rd_block(8'd0, 6, "full bank");
    wr_block(ADDR, 8'd1, 8'd3, '{8'h3C, 8'hA1, 8'h77}, "block of three");
    rd_block(8'd1, 3, "after block");
    wr_block(ADDR, 8'd3, 8'd3, '{8'h11, 8'h22, 8'h33}, "R6 over id");
    rd_block(8'd3, 3, "id and empty");
    wr_block(ADDR, 8'd0, 8'd0, '{8'h00, 8'hF0}, "R3 zero count");
    chk(ctl0 == 8'h07, "R3 reg0 untouched", ctl0, 8'h07);
    wr_block(ADDR, 8'd2, 8'd1, '{8'hC3, 8'h99}, "R4 short count");
    chk(spr == 8'h11, "R4 reg3 untouched", spr, 8'h11);
    wr_block(7'h6F, 8'd0, 8'd1, '{8'h00}, "R1 near address");
    wr_block(7'h2E, 8'd1, 8'd1, '{8'h00}, "R1 far address");
    chk(oem == 8'h3C, "R1 reg1 untouched", oem, 8'h3C);
    wr_block(ADDR, 8'd0, 8'd4, '{8'h05}, "R8 early stop");
    chk(ctl0 == 8'h05, "R8 reg0 kept", ctl0, 8'h05);
    wr_block(ADDR, 8'd0, 8'd2, '{8'hC6, 8'h81}, "after early stop");
    rd_block(8'd0, 2, "final");
    rd_block(8'd7, 1, "R6 beyond bank");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule